// File: doc/BRIEF.md
# Chained I2C Address Assignment Controller

This block gives each of several identical devices on one I2C bus its own slave address. All devices power up answering at the address kept in their nonvolatile cell. A host opens an assignment round with a single write to the broadcast address 30h that carries an unlock code and a shared temporary address. Every device then answers at that temporary address, with address bit 3 taken from its bank pin, and pulls its chain output low.

The devices are wired in a chain. Each chain output drives the next device's chain input, and the first chain input is tied high. Only a device whose chain input is high takes the new address the host writes to register 11h. That device then drives its chain output high, which enables the next device. It locks its address and pulses a store strobe so the external cell saves the address and the mode flag. If the host does not assign an address within a set number of timer ticks, the device goes back to its old address.

The I2C bit engine and the storage cell sit outside the block. Transactions arrive already decoded: target address, register byte and data byte, with one valid strobe. The mode flag from the cell drives the mode output only after a reset or a software reset request.

Top module: `aprog_ctrl`

## Requirements
- R1: While rst_n is low at a clock edge (synchronous, active low), the block reloads its base address from nv_addr and its mode output from nv_auto. It drives chain_out high and holds wr_ack and nv_we low. dev_addr is always the active address with bit 3 replaced by bank_pin.
- R2: wr_ack is high for the one cycle after a write whose target is 30h or equals dev_addr, whatever bank_pin is. It is low after any other write and when there is no write.
- R3: A write to 30h with register byte AAh and data bits 6:0 not equal to 30h starts a round. Any other write to 30h leaves the address and chain_out unchanged. So does an unlock write while a round is already running.
- R4: During a round, dev_addr equals the temporary address (data bits 6:0 of the unlock write) with bit 3 replaced by bank_pin, and chain_out is low.
- R5: During a round, a write to dev_addr with register byte 11h while chain_in is high ends the round. The new address is data bits 6:0 with bit 3 replaced by bank_pin. chain_out goes high and the round closes.
- R6: Accepting an address raises nv_we for exactly one cycle. In that cycle nv_wdata holds the written bit 7 (the mode flag) in bit 7 and the new address in bits 6:0.
- R7: A register 11h write has no effect on the address or on nv_we when chain_in is low or when no round is running.
- R8: If no address is accepted within TIMEOUT_TICKS ticks after the unlock write, the round ends on that tick. The address set before the round comes back, chain_out goes high, and nothing is stored.
- R9: A write with register byte 1Ah and data bit 7 set, at dev_addr or 30h, loads auto_mode from nv_auto. Other than that and R1, auto_mode never changes, even when nv_auto does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset (power-on or external) |
| tick | input | 1 | Timebase pulse for the round timeout |
| wr_valid | input | 1 | A decoded write transaction is present |
| wr_addr | input | 7 | Target slave address of the write |
| wr_reg | input | 8 | Register byte of the write |
| wr_data | input | 8 | Data byte of the write |
| chain_in | input | 1 | Chain enable from the previous device |
| bank_pin | input | 1 | Level that replaces address bit 3 |
| nv_addr | input | 7 | Address held in the nonvolatile cell |
| nv_auto | input | 1 | Mode flag held in the nonvolatile cell |
| chain_out | output | 1 | Chain enable to the next device |
| dev_addr | output | 7 | Address the device currently answers at |
| auto_mode | output | 1 | Latched stand-alone mode flag |
| wr_ack | output | 1 | The last write was addressed to this device |
| nv_we | output | 1 | Store strobe for the nonvolatile cell |
| nv_wdata | output | 8 | Mode flag and address to store |

## Verification
Every result of a write is registered. Address, chain, ack, store and mode changes become visible one edge after the write is sampled, and the bench drives writes at a falling edge and checks them at the next falling edge. Bit 3 of dev_addr follows bank_pin with no delay. The timeout fires on the TIMEOUT_TICKS-th tick edge after the unlock edge, so with tick held high the bench checks that the round is still open after TIMEOUT_TICKS-1 edges and closed after one more. Store counts come from a cell model that samples nv_we at rising edges, and the bench reads them one idle cycle after the write.

// File: rtl/aprog_pkg.sv
package aprog_pkg;
    localparam int ADDR_W   = 7;
    localparam int DATA_W   = 8;
    localparam int BANK_BIT = 3;

    localparam logic [ADDR_W-1:0] BCAST_ADDR    = 7'h30;
    localparam logic [DATA_W-1:0] UNLOCK_CODE   = 8'hAA;
    localparam logic [DATA_W-1:0] REG_SLAVE     = 8'h11;
    localparam logic [DATA_W-1:0] REG_SOFT_RST  = 8'h1A;
    localparam int                SOFT_RST_BIT  = 7;
    localparam int                MODE_BIT      = 7;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_ARMED = 1'b1
    } aprog_state_e;

    typedef struct packed {
        aprog_state_e       st;
        logic [ADDR_W-1:0]  base;
        logic [ADDR_W-1:0]  prev;
        logic [ADDR_W-1:0]  temp;
        logic               auto_m;
        logic               chain;
        logic               ack;
        logic               we;
        logic [DATA_W-1:0]  wdata;
    } aprog_regs_t;

    function automatic logic [ADDR_W-1:0] force_bank(input logic [ADDR_W-1:0] a,
                                                     input logic pin);
        logic [ADDR_W-1:0] r;
        r = a;
        r[BANK_BIT] = pin;
        return r;
    endfunction
endpackage

// File: rtl/aprog_addr_sel.sv
module aprog_addr_sel
    import aprog_pkg::*;
(
    input  logic              armed,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] temp,
    input  logic              bank_pin,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W-1:0] ans_addr,
    output logic              hit_me,
    output logic              hit_bc
);
    logic [ADDR_W-1:0] active;

    always_comb begin
        active   = armed ? temp : base;
        ans_addr = force_bank(active, bank_pin);
        hit_me   = (wr_addr == ans_addr);
        hit_bc   = (wr_addr == BCAST_ADDR);
    end
endmodule

// File: rtl/aprog_timer.sv
module aprog_timer #(
    parameter int TIMEOUT_TICKS = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    input  logic tick,
    output logic expire
);
    localparam int CNT_W = $clog2(TIMEOUT_TICKS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_TICKS - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        expire = run && tick && (cnt_q == LAST);
        cnt_d  = cnt_q;
        if (!rst_n || clear) begin
            cnt_d = '0;
        end else if (run && tick && !expire) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/aprog_ctrl.sv
module aprog_ctrl
    import aprog_pkg::*;
#(
    parameter int TIMEOUT_TICKS = 100000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_reg,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              chain_in,
    input  logic              bank_pin,
    input  logic [ADDR_W-1:0] nv_addr,
    input  logic              nv_auto,
    output logic              chain_out,
    output logic [ADDR_W-1:0] dev_addr,
    output logic              auto_mode,
    output logic              wr_ack,
    output logic              nv_we,
    output logic [DATA_W-1:0] nv_wdata
);
    aprog_regs_t r_d, r_q;

    logic              armed;
    logic [ADDR_W-1:0] ans_addr;
    logic              hit_me, hit_bc;
    logic              expire;
    logic              arm_req, accept, soft_rst, arm_go;
    logic [ADDR_W-1:0] new_addr;

    assign armed = (r_q.st == ST_ARMED);

    aprog_addr_sel u_sel (
        .armed    (armed),
        .base     (r_q.base),
        .temp     (r_q.temp),
        .bank_pin (bank_pin),
        .wr_addr  (wr_addr),
        .ans_addr (ans_addr),
        .hit_me   (hit_me),
        .hit_bc   (hit_bc)
    );

    aprog_timer #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (arm_go),
        .run    (armed),
        .tick   (tick),
        .expire (expire)
    );

    always_comb begin
        arm_req  = wr_valid && hit_bc && (wr_reg == UNLOCK_CODE)
                   && (wr_data[ADDR_W-1:0] != BCAST_ADDR);
        accept   = wr_valid && armed && hit_me && (wr_reg == REG_SLAVE) && chain_in;
        soft_rst = wr_valid && (hit_me || hit_bc) && (wr_reg == REG_SOFT_RST)
                   && wr_data[SOFT_RST_BIT];
        new_addr = force_bank(wr_data[ADDR_W-1:0], bank_pin);
        arm_go   = 1'b0;

        r_d      = r_q;
        r_d.ack  = 1'b0;
        r_d.we   = 1'b0;

        if (!rst_n) begin
            r_d.st     = ST_IDLE;
            r_d.base   = nv_addr;
            r_d.prev   = nv_addr;
            r_d.temp   = '0;
            r_d.auto_m = nv_auto;
            r_d.chain  = 1'b1;
            r_d.wdata  = '0;
        end else begin
            if (wr_valid) begin
                r_d.ack = hit_bc || hit_me;
            end
            if (armed) begin
                if (accept) begin
                    r_d.st    = ST_IDLE;
                    r_d.base  = new_addr;
                    r_d.chain = 1'b1;
                    r_d.we    = 1'b1;
                    r_d.wdata = {wr_data[MODE_BIT], new_addr};
                end else if (expire) begin
                    r_d.st    = ST_IDLE;
                    r_d.base  = r_q.prev;
                    r_d.chain = 1'b1;
                end
            end else if (arm_req) begin
                arm_go    = 1'b1;
                r_d.st    = ST_ARMED;
                r_d.prev  = r_q.base;
                r_d.temp  = wr_data[ADDR_W-1:0];
                r_d.chain = 1'b0;
            end
            if (soft_rst) begin
                r_d.auto_m = nv_auto;
            end
        end
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    assign chain_out = r_q.chain;
    assign dev_addr  = ans_addr;
    assign auto_mode = r_q.auto_m;
    assign wr_ack    = r_q.ack;
    assign nv_we     = r_q.we;
    assign nv_wdata  = r_q.wdata;
endmodule

// File: rtl/aprog_ctrl_chk.sv
module aprog_ctrl_chk
    import aprog_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_valid,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_reg,
    input logic              chain_in,
    input logic              bank_pin,
    input logic              chain_out,
    input logic [ADDR_W-1:0] dev_addr,
    input logic              auto_mode,
    input logic              wr_ack,
    input logic              nv_we,
    input logic [DATA_W-1:0] nv_wdata
);
    a_r2_ack_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ack |-> $past(wr_valid));

    a_r3_round_needs_unlock: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(chain_out) |-> $past(wr_valid && wr_addr == BCAST_ADDR && wr_reg == UNLOCK_CODE));

    a_r6_store_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        nv_we |=> !nv_we);

    a_r6_store_matches_addr: assert property (@(posedge clk) disable iff (!rst_n)
        nv_we |-> (nv_wdata[ADDR_W-1:0] == dev_addr) && chain_out);

    a_r5_bank_bit_follows_pin: assert property (@(posedge clk) disable iff (!rst_n)
        dev_addr[BANK_BIT] == bank_pin);

    a_r7_store_needs_chain: assert property (@(posedge clk) disable iff (!rst_n)
        nv_we |-> $past(chain_in));

    a_r9_mode_only_on_request: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(auto_mode) |-> $past(wr_valid) && ($past(wr_reg) == REG_SOFT_RST));
endmodule

bind aprog_ctrl aprog_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_valid  (wr_valid),
    .wr_addr   (wr_addr),
    .wr_reg    (wr_reg),
    .chain_in  (chain_in),
    .bank_pin  (bank_pin),
    .chain_out (chain_out),
    .dev_addr  (dev_addr),
    .auto_mode (auto_mode),
    .wr_ack    (wr_ack),
    .nv_we     (nv_we),
    .nv_wdata  (nv_wdata)
);

// File: tb/aprog_ctrl_tb.sv
module aprog_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int TMO        = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_valid = 1'b0;
    logic [6:0] wr_addr = '0;
    logic [7:0] wr_reg = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] bank = 3'b010;

    logic [6:0] nv_addr [3];
    logic       nv_auto [3];
    logic [2:0] cout, amode, ack, we;
    logic [6:0] daddr [3];
    logic [7:0] wdata [3];
    int         we_cnt [3];

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        for (int i = 0; i < 3; i++) begin
            nv_addr[i] = 7'h40;
            nv_auto[i] = 1'b0;
            we_cnt[i]  = 0;
        end
    end

    aprog_ctrl #(.TIMEOUT_TICKS(TMO)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_valid(wr_valid),
        .wr_addr(wr_addr), .wr_reg(wr_reg), .wr_data(wr_data),
        .chain_in(1'b1), .bank_pin(bank[0]), .nv_addr(nv_addr[0]), .nv_auto(nv_auto[0]),
        .chain_out(cout[0]), .dev_addr(daddr[0]), .auto_mode(amode[0]),
        .wr_ack(ack[0]), .nv_we(we[0]), .nv_wdata(wdata[0]));

    aprog_ctrl #(.TIMEOUT_TICKS(TMO)) u_dut_b (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_valid(wr_valid),
        .wr_addr(wr_addr), .wr_reg(wr_reg), .wr_data(wr_data),
        .chain_in(cout[0]), .bank_pin(bank[1]), .nv_addr(nv_addr[1]), .nv_auto(nv_auto[1]),
        .chain_out(cout[1]), .dev_addr(daddr[1]), .auto_mode(amode[1]),
        .wr_ack(ack[1]), .nv_we(we[1]), .nv_wdata(wdata[1]));

    aprog_ctrl #(.TIMEOUT_TICKS(TMO)) u_dut_c (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_valid(wr_valid),
        .wr_addr(wr_addr), .wr_reg(wr_reg), .wr_data(wr_data),
        .chain_in(cout[1]), .bank_pin(bank[2]), .nv_addr(nv_addr[2]), .nv_auto(nv_auto[2]),
        .chain_out(cout[2]), .dev_addr(daddr[2]), .auto_mode(amode[2]),
        .wr_ack(ack[2]), .nv_we(we[2]), .nv_wdata(wdata[2]));

    // nonvolatile cell model: captures the store strobe at the rising edge
    always @(posedge clk) begin
        for (int i = 0; i < 3; i++) begin
            if (we[i]) begin
                nv_addr[i] <= wdata[i][6:0];
                nv_auto[i] <= wdata[i][7];
                we_cnt[i]  <= we_cnt[i] + 1;
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [6:0] a, input logic [7:0] r, input logic [7:0] d);
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = a; wr_reg = r; wr_data = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic chk_addrs(input string tag, input logic [6:0] a0,
                             input logic [6:0] a1, input logic [6:0] a2);
        chk({tag, " dev0 addr"}, int'(daddr[0]), int'(a0));
        chk({tag, " dev1 addr"}, int'(daddr[1]), int'(a1));
        chk({tag, " dev2 addr"}, int'(daddr[2]), int'(a2));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_state();
        do_reset();
        chk_addrs("R1 reset", 7'h40, 7'h48, 7'h40);
        chk("R1 reset chain", int'(cout), 7);
        chk("R1 reset mode", int'(amode), 0);
        chk("R1 reset ack/we", int'({ack, we}), 0);
    endtask

    task automatic t_ignored_broadcasts();
        bus_wr(7'h30, 8'h55, 8'h20);
        chk("R2 broadcast ack", int'(ack), 7);
        chk_addrs("R3 wrong code", 7'h40, 7'h48, 7'h40);
        chk("R3 wrong code chain", int'(cout), 7);
        bus_wr(7'h30, 8'hAA, 8'h30);
        chk_addrs("R3 temp 30h", 7'h40, 7'h48, 7'h40);
        chk("R3 temp 30h chain", int'(cout), 7);
        bus_wr(7'h40, 8'h11, 8'h15);
        chk("R7 idle reg write we", int'(we), 0);
        chk_addrs("R7 idle reg write", 7'h40, 7'h48, 7'h40);
    endtask

    task automatic t_arm();
        bus_wr(7'h30, 8'hAA, 8'h20);
        chk("R2 arm ack", int'(ack), 7);
        chk_addrs("R4 armed", 7'h20, 7'h28, 7'h20);
        chk("R4 armed chain", int'(cout), 0);
        bus_wr(7'h55, 8'h00, 8'h00);
        chk("R2 no ack elsewhere", int'(ack), 0);
        bus_wr(7'h30, 8'hAA, 8'h44);
        chk_addrs("R3 rearm ignored", 7'h20, 7'h28, 7'h20);
    endtask

    task automatic t_chain();
        bus_wr(7'h28, 8'h11, 8'h66);
        chk("R7 chain low we", int'(we), 0);
        chk_addrs("R7 chain low", 7'h20, 7'h28, 7'h20);

        bus_wr(7'h20, 8'h11, 8'h83);
        chk("R2 ack at temp", int'(ack), 5);
        chk_addrs("R5 dev0 takes", 7'h03, 7'h28, 7'h20);
        chk("R5 chain after dev0", int'(cout), 1);
        chk("R6 dev0 store", int'(we), 1);
        chk("R6 dev0 data", int'(wdata[0]), 8'h83);
        @(negedge clk);
        chk("R6 store once", int'(we), 0);

        bus_wr(7'h28, 8'h11, 8'h04);
        chk_addrs("R5 dev1 bank forced", 7'h03, 7'h0C, 7'h20);
        chk("R6 dev1 data", int'(wdata[1]), 8'h0C);
        chk("R5 chain after dev1", int'(cout), 3);

        bus_wr(7'h20, 8'h11, 8'h5D);
        chk_addrs("R5 dev2 bank forced", 7'h03, 7'h0C, 7'h55);
        chk("R6 dev2 data", int'(wdata[2]), 8'h55);
        chk("R5 chain after dev2", int'(cout), 7);

        bus_wr(7'h03, 8'h11, 8'h10);
        @(negedge clk);
        chk_addrs("R7 locked", 7'h03, 7'h0C, 7'h55);
        chk("R6 dev0 store count", we_cnt[0], 1);
        chk("R6 dev1 store count", we_cnt[1], 1);
        chk("R6 dev2 store count", we_cnt[2], 1);
    endtask

    task automatic t_mode();
        chk("R9 stored flag", int'(nv_auto[0]), 1);
        chk("R9 mode not applied yet", int'(amode), 0);
        bus_wr(7'h03, 8'h1A, 8'h7F);
        chk("R9 bit7 clear ignored", int'(amode), 0);
        bus_wr(7'h03, 8'h1A, 8'h80);
        chk("R9 soft reset applies", int'(amode), 1);
    endtask

    task automatic t_timeout();
        @(negedge clk);
        tick = 1'b1;
        bus_wr(7'h30, 8'hAA, 8'h3A);
        chk_addrs("R4 armed again", 7'h32, 7'h3A, 7'h32);
        repeat (TMO - 1) @(negedge clk);
        chk_addrs("R8 before expiry", 7'h32, 7'h3A, 7'h32);
        chk("R8 before expiry chain", int'(cout), 0);
        @(negedge clk);
        chk_addrs("R8 restored", 7'h03, 7'h0C, 7'h55);
        chk("R8 restored chain", int'(cout), 7);
        @(negedge clk);
        chk("R8 no store", we_cnt[0] + we_cnt[1] + we_cnt[2], 3);
        tick = 1'b0;
    endtask

    task automatic t_reset_reload();
        do_reset();
        chk_addrs("R1 reload", 7'h03, 7'h0C, 7'h55);
        chk("R9 mode after reset", int'(amode), 1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        t_reset_state();
        t_ignored_broadcasts();
        t_arm();
        t_chain();
        t_mode();
        t_timeout();
        t_reset_reload();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end
endmodule